// File: doc/BRIEF.md
# Branch Condition and Next-PC Resolver

This unit sits in the execute stage of a 64-bit register machine and settles every control-transfer instruction. For each presented instruction it takes the opcode, the register-select field of the source operand, both register values, the 32-bit immediate, the 16-bit signed displacement and the current program counter, which counts whole 8-byte instruction slots. One cycle later it reports whether control moves, the program counter to fetch next, a call request with its kind and target, a return request, and a flag for encodings it refuses.

Opcode bits [2:0] give the class: 5 is the full-width class and 6 the low-half class. Bit 3 picks the second operand, 0 for the immediate and 1 for the source register. Bits [7:4] give the condition or action. One signed comparator on 65-bit extended operands serves every ordered test. A separate AND-reduce serves the bit-test condition. Calls are decoded, and the local-call return address is handed out on its own port. The helper machinery and the return stack live outside this unit.

Top module: `jump_resolve`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every output is zero.
- R2: Class 5 compares all 64 bits. Class 6 compares only bits [31:0] of both operands, so the upper halves have no effect.
- R3: Opcode bit 3 = 1 selects the source register as second operand. Bit 3 = 0 selects the immediate, sign-extended from 32 bits in class 5 and zero-extended in class 6.
- R4: Code 1 is taken on equality, code 5 on inequality, and code 4 when the bitwise AND of the operands is nonzero.
- R5: Unsigned tests are code 2 (greater), code 3 (greater or equal), code 0xa (less) and code 0xb (less or equal).
- R6: Signed two's-complement tests are code 6 (greater), code 7 (greater or equal), code 0xc (less) and code 0xd (less or equal).
- R7: When taken, next_pc = pc + 1 + sign-extended offset, where a negative offset moves backward. When not taken, next_pc = pc + 1.
- R8: Code 0 in class 5 is always taken.
- R9: Code 8 in class 5 raises call_req with call_kind equal to the source-register field. Kind 0 (helper by address) and kind 2 (helper by type ID) give call_target = zero-extended immediate, next_pc = pc + 1 and no taken. Kind 1 (local) gives call_target = next_pc = pc + 1 + offset, taken = 1 and ret_addr = pc + 1. A field value of 3 or more is illegal.
- R10: Code 9 in class 5 raises exit_req, with taken low and next_pc = pc + 1.
- R11: Codes 0xe and 0xf, codes 0, 8 and 9 in class 6, and any class other than 5 or 6 raise illegal. An illegal instruction never raises taken, call_req or exit_req, and its next_pc is pc + 1.
- R12: Every result appears with out_valid exactly one cycle after in_valid. The outputs are zero when no instruction was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| opcode | input | 8 | Code [7:4], operand select [3], class [2:0] |
| src_field | input | 4 | Source-register field, used as call kind |
| dst_val | input | 64 | First comparison operand |
| src_val | input | 64 | Register form of the second operand |
| imm | input | 32 | Immediate operand or helper identifier |
| offset | input | 16 | Signed displacement in slots |
| pc | input | 32 | Current instruction slot |
| out_valid | output | 1 | Result valid |
| taken | output | 1 | Control moves away from pc + 1 |
| next_pc | output | 32 | Slot to fetch next |
| call_req | output | 1 | Call decoded |
| call_kind | output | 2 | 0 helper by address, 1 local, 2 helper by type ID |
| call_target | output | 64 | Helper identifier or local target slot |
| ret_addr | output | 32 | Return slot for a local call |
| exit_req | output | 1 | Return from function decoded |
| illegal | output | 1 | Encoding refused |

## Verification
Each ordered test is tried with operands that are equal, with operands whose order differs between the signed and unsigned views (1 against all-ones), and with operands that differ only in the upper half. Together these separate signedness errors, off-by-one boundary errors and width errors. Immediate forms use an all-ones and a high-bit immediate, which shows whether the extension follows the class. Calls are tried with each kind field, and jump/call/exit are tried in the narrow class. Positive and negative displacements check the target adder.

// File: rtl/jmpu_pkg.sv
package jmpu_pkg;

    localparam logic [2:0] CLS_WIDE   = 3'd5;
    localparam logic [2:0] CLS_NARROW = 3'd6;

    localparam logic [3:0] OP_JA   = 4'h0;
    localparam logic [3:0] OP_EQ   = 4'h1;
    localparam logic [3:0] OP_UGT  = 4'h2;
    localparam logic [3:0] OP_UGE  = 4'h3;
    localparam logic [3:0] OP_SET  = 4'h4;
    localparam logic [3:0] OP_NE   = 4'h5;
    localparam logic [3:0] OP_SGT  = 4'h6;
    localparam logic [3:0] OP_SGE  = 4'h7;
    localparam logic [3:0] OP_CALL = 4'h8;
    localparam logic [3:0] OP_EXIT = 4'h9;
    localparam logic [3:0] OP_ULT  = 4'ha;
    localparam logic [3:0] OP_ULE  = 4'hb;
    localparam logic [3:0] OP_SLT  = 4'hc;
    localparam logic [3:0] OP_SLE  = 4'hd;

    localparam logic [1:0] KIND_HELPER_ADDR = 2'd0;
    localparam logic [1:0] KIND_LOCAL       = 2'd1;
    localparam logic [1:0] KIND_HELPER_TYPE = 2'd2;

    typedef enum logic [2:0] {
        REL_NONE,
        REL_EQ,
        REL_NE,
        REL_SET,
        REL_GT,
        REL_GE,
        REL_LT,
        REL_LE
    } rel_e;

    typedef struct packed {
        logic       narrow;
        logic       use_reg;
        logic       is_ja;
        logic       is_cond;
        logic       is_call;
        logic       is_exit;
        logic       signed_cmp;
        rel_e       rel;
        logic [1:0] kind;
        logic       illegal;
    } dec_t;

endpackage

// File: rtl/jmpu_decode.sv
module jmpu_decode
    import jmpu_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic [3:0] src_field,
    output dec_t       dec
);

    logic [2:0] cls;
    logic [3:0] code;
    logic       class_ok;
    logic       narrow;

    assign cls      = opcode[2:0];
    assign code     = opcode[7:4];
    assign narrow   = (cls == CLS_NARROW);
    assign class_ok = (cls == CLS_WIDE) || narrow;

    always_comb begin
        dec            = '0;
        dec.narrow     = narrow;
        dec.use_reg    = opcode[3];
        dec.rel        = REL_NONE;
        dec.kind       = src_field[1:0];
        dec.illegal    = !class_ok;
        unique case (code)
            OP_JA:   begin dec.is_ja = 1'b1; dec.illegal |= narrow; end
            OP_EQ:   begin dec.is_cond = 1'b1; dec.rel = REL_EQ; end
            OP_NE:   begin dec.is_cond = 1'b1; dec.rel = REL_NE; end
            OP_SET:  begin dec.is_cond = 1'b1; dec.rel = REL_SET; end
            OP_UGT:  begin dec.is_cond = 1'b1; dec.rel = REL_GT; end
            OP_UGE:  begin dec.is_cond = 1'b1; dec.rel = REL_GE; end
            OP_ULT:  begin dec.is_cond = 1'b1; dec.rel = REL_LT; end
            OP_ULE:  begin dec.is_cond = 1'b1; dec.rel = REL_LE; end
            OP_SGT:  begin dec.is_cond = 1'b1; dec.rel = REL_GT; dec.signed_cmp = 1'b1; end
            OP_SGE:  begin dec.is_cond = 1'b1; dec.rel = REL_GE; dec.signed_cmp = 1'b1; end
            OP_SLT:  begin dec.is_cond = 1'b1; dec.rel = REL_LT; dec.signed_cmp = 1'b1; end
            OP_SLE:  begin dec.is_cond = 1'b1; dec.rel = REL_LE; dec.signed_cmp = 1'b1; end
            OP_CALL: begin
                dec.is_call  = 1'b1;
                dec.illegal |= narrow || (src_field > 4'd2);
            end
            OP_EXIT: begin dec.is_exit = 1'b1; dec.illegal |= narrow; end
            default: dec.illegal = 1'b1;
        endcase
        if (dec.illegal) begin
            dec.is_ja   = 1'b0;
            dec.is_cond = 1'b0;
            dec.is_call = 1'b0;
            dec.is_exit = 1'b0;
            dec.rel     = REL_NONE;
        end
    end

endmodule

// File: rtl/jmpu_compare.sv
module jmpu_compare
    import jmpu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  logic            narrow,
    input  logic            signed_cmp,
    input  rel_e            rel,
    output logic            hit
);

    localparam int HALF = XLEN / 2;

    logic [XLEN:0] ax;
    logic [XLEN:0] bx;
    logic          lt;
    logic          eq;
    logic          any_set;

    // Both views are widened by one bit so that a single signed compare
    // yields either the signed or the unsigned ordering.
    always_comb begin
        if (narrow) begin
            ax = {{(HALF+1){signed_cmp & op_a[HALF-1]}}, op_a[HALF-1:0]};
            bx = {{(HALF+1){signed_cmp & op_b[HALF-1]}}, op_b[HALF-1:0]};
            any_set = |(op_a[HALF-1:0] & op_b[HALF-1:0]);
        end else begin
            ax = {signed_cmp & op_a[XLEN-1], op_a};
            bx = {signed_cmp & op_b[XLEN-1], op_b};
            any_set = |(op_a & op_b);
        end
    end

    assign lt = $signed(ax) < $signed(bx);
    assign eq = (ax == bx);

    always_comb begin
        unique case (rel)
            REL_EQ:  hit = eq;
            REL_NE:  hit = !eq;
            REL_SET: hit = any_set;
            REL_GT:  hit = !lt && !eq;
            REL_GE:  hit = !lt;
            REL_LT:  hit = lt;
            REL_LE:  hit = lt || eq;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/jmpu_target.sv
module jmpu_target #(
    parameter int PC_W  = 32,
    parameter int OFF_W = 16
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    output logic [PC_W-1:0]  seq_pc,
    output logic [PC_W-1:0]  jump_pc
);

    logic [PC_W-1:0] off_ext;

    assign off_ext = {{(PC_W-OFF_W){offset[OFF_W-1]}}, offset};
    assign seq_pc  = pc + PC_W'(1);
    assign jump_pc = seq_pc + off_ext;

endmodule

// File: rtl/jump_resolve.sv
module jump_resolve
    import jmpu_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IMM_W = 32,
    parameter int OFF_W = 16,
    parameter int PC_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       opcode,
    input  logic [3:0]       src_field,
    input  logic [XLEN-1:0]  dst_val,
    input  logic [XLEN-1:0]  src_val,
    input  logic [IMM_W-1:0] imm,
    input  logic [OFF_W-1:0] offset,
    input  logic [PC_W-1:0]  pc,
    output logic             out_valid,
    output logic             taken,
    output logic [PC_W-1:0]  next_pc,
    output logic             call_req,
    output logic [1:0]       call_kind,
    output logic [XLEN-1:0]  call_target,
    output logic [PC_W-1:0]  ret_addr,
    output logic             exit_req,
    output logic             illegal
);

    localparam int EXT_W = XLEN - IMM_W;

    typedef struct packed {
        logic             valid;
        logic             taken;
        logic [PC_W-1:0]  next_pc;
        logic             call;
        logic [1:0]       kind;
        logic [XLEN-1:0]  target;
        logic [PC_W-1:0]  ret;
        logic             exit_r;
        logic             illegal;
    } res_t;

    dec_t            dec;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] op_b;
    logic            hit;
    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] jump_pc;
    res_t            res_d;
    res_t            res_q;

    jmpu_decode u_dec (
        .opcode    (opcode),
        .src_field (src_field),
        .dec       (dec)
    );

    // Wide class sign-extends the immediate, narrow class uses it as is.
    assign imm_ext = dec.narrow ? {{EXT_W{1'b0}}, imm}
                                : {{EXT_W{imm[IMM_W-1]}}, imm};
    assign op_b    = dec.use_reg ? src_val : imm_ext;

    jmpu_compare #(.XLEN(XLEN)) u_cmp (
        .op_a       (dst_val),
        .op_b       (op_b),
        .narrow     (dec.narrow),
        .signed_cmp (dec.signed_cmp),
        .rel        (dec.rel),
        .hit        (hit)
    );

    jmpu_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
        .pc      (pc),
        .offset  (offset),
        .seq_pc  (seq_pc),
        .jump_pc (jump_pc)
    );

    always_comb begin
        res_d = '0;
        if (in_valid) begin
            res_d.valid   = 1'b1;
            res_d.next_pc = seq_pc;
            if (dec.illegal) begin
                res_d.illegal = 1'b1;
            end else if (dec.is_ja || (dec.is_cond && hit)) begin
                res_d.taken   = 1'b1;
                res_d.next_pc = jump_pc;
            end else if (dec.is_call) begin
                res_d.call = 1'b1;
                res_d.kind = dec.kind;
                if (dec.kind == KIND_LOCAL) begin
                    res_d.taken   = 1'b1;
                    res_d.next_pc = jump_pc;
                    res_d.target  = XLEN'(jump_pc);
                    res_d.ret     = seq_pc;
                end else begin
                    res_d.target  = {{EXT_W{1'b0}}, imm};
                end
            end else if (dec.is_exit) begin
                res_d.exit_r = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid   = res_q.valid;
    assign taken       = res_q.taken;
    assign next_pc     = res_q.next_pc;
    assign call_req    = res_q.call;
    assign call_kind   = res_q.kind;
    assign call_target = res_q.target;
    assign ret_addr    = res_q.ret;
    assign exit_req    = res_q.exit_r;
    assign illegal     = res_q.illegal;

endmodule

// File: rtl/jmpu_chk.sv
module jmpu_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [7:0]      opcode,
    input logic [PC_W-1:0] pc,
    input logic            out_valid,
    input logic            taken,
    input logic [PC_W-1:0] next_pc,
    input logic            call_req,
    input logic [1:0]      call_kind,
    input logic [PC_W-1:0] ret_addr,
    input logic            exit_req,
    input logic            illegal
);

    // R12
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R11
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({call_req, exit_req, illegal}) && !(illegal && taken));

    // R7
    seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (taken || next_pc == $past(pc) + PC_W'(1)));

    // R9
    ret_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!(call_req && call_kind == 2'd1) || ret_addr == $past(pc) + PC_W'(1)));

    // R11
    narrow_ja_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 8'h06) |=> illegal);

    // R10
    exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exit_req |-> !taken);

endmodule

bind jump_resolve jmpu_chk #(.PC_W(PC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opcode    (opcode),
    .pc        (pc),
    .out_valid (out_valid),
    .taken     (taken),
    .next_pc   (next_pc),
    .call_req  (call_req),
    .call_kind (call_kind),
    .ret_addr  (ret_addr),
    .exit_req  (exit_req),
    .illegal   (illegal)
);

// File: tb/sim_jump_resolve.sv
module sim_jump_resolve;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  opcode = '0;
    logic [3:0]  src_field = '0;
    logic [63:0] dst_val = '0;
    logic [63:0] src_val = '0;
    logic [31:0] imm = '0;
    logic [15:0] offset = '0;
    logic [31:0] pc = '0;
    logic        out_valid, taken, call_req, exit_req, illegal;
    logic [31:0] next_pc, ret_addr;
    logic [1:0]  call_kind;
    logic [63:0] call_target;

    typedef struct packed {
        logic        tk;
        logic [31:0] npc;
        logic        creq;
        logic [1:0]  ck;
        logic [63:0] ctgt;
        logic [31:0] ra;
        logic        ex;
        logic        il;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    errors = 0;

    always #5 clk = ~clk;

    jump_resolve u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .src_field(src_field), .dst_val(dst_val), .src_val(src_val),
        .imm(imm), .offset(offset), .pc(pc), .out_valid(out_valid),
        .taken(taken), .next_pc(next_pc), .call_req(call_req),
        .call_kind(call_kind), .call_target(call_target), .ret_addr(ret_addr),
        .exit_req(exit_req), .illegal(illegal)
    );

    function automatic exp_t model(input logic [7:0] op, input logic [3:0] sf,
                                   input logic [63:0] dv, input logic [63:0] sv,
                                   input logic [31:0] im, input logic [15:0] off,
                                   input logic [31:0] p);
        exp_t        e;
        logic [63:0] b;
        logic [3:0]  c;
        logic        wide, ill, cond;
        logic [31:0] tgt;
        e    = '0;
        c    = op[7:4];
        wide = (op[2:0] == 3'd5);
        ill  = !(op[2:0] == 3'd5 || op[2:0] == 3'd6);
        b    = op[3] ? sv : (wide ? {{32{im[31]}}, im} : {32'b0, im});
        tgt  = p + 32'd1 + {{16{off[15]}}, off};
        cond = 1'b0;
        if (wide) begin
            case (c)
                4'h1: cond = dv == b;
                4'h5: cond = dv != b;
                4'h4: cond = (dv & b) != 0;
                4'h2: cond = dv > b;
                4'h3: cond = dv >= b;
                4'ha: cond = dv < b;
                4'hb: cond = dv <= b;
                4'h6: cond = $signed(dv) > $signed(b);
                4'h7: cond = $signed(dv) >= $signed(b);
                4'hc: cond = $signed(dv) < $signed(b);
                4'hd: cond = $signed(dv) <= $signed(b);
                default: cond = 1'b0;
            endcase
        end else begin
            case (c)
                4'h1: cond = dv[31:0] == b[31:0];
                4'h5: cond = dv[31:0] != b[31:0];
                4'h4: cond = (dv[31:0] & b[31:0]) != 0;
                4'h2: cond = dv[31:0] > b[31:0];
                4'h3: cond = dv[31:0] >= b[31:0];
                4'ha: cond = dv[31:0] < b[31:0];
                4'hb: cond = dv[31:0] <= b[31:0];
                4'h6: cond = $signed(dv[31:0]) > $signed(b[31:0]);
                4'h7: cond = $signed(dv[31:0]) >= $signed(b[31:0]);
                4'hc: cond = $signed(dv[31:0]) < $signed(b[31:0]);
                4'hd: cond = $signed(dv[31:0]) <= $signed(b[31:0]);
                default: cond = 1'b0;
            endcase
        end
        e.npc = p + 32'd1;
        case (c)
            4'h0: if (!wide) ill = 1'b1; else cond = 1'b1;
            4'h8: if (!wide || sf > 4'd2) ill = 1'b1;
                  else begin
                      e.creq = 1'b1;
                      e.ck   = sf[1:0];
                      if (sf == 4'd1) begin
                          e.ctgt = {32'b0, tgt};
                          e.ra   = p + 32'd1;
                          cond   = 1'b1;
                      end else begin
                          e.ctgt = {32'b0, im};
                      end
                  end
            4'h9: if (!wide) ill = 1'b1; else e.ex = 1'b1;
            4'he, 4'hf: ill = 1'b1;
            default: ;
        endcase
        if (ill) begin
            e     = '0;
            e.npc = p + 32'd1;
            e.il  = 1'b1;
        end else if (cond) begin
            e.tk  = 1'b1;
            e.npc = tgt;
        end
        return e;
    endfunction

    task automatic drive(input logic [7:0] op, input logic [3:0] sf,
                         input logic [63:0] dv, input logic [63:0] sv,
                         input logic [31:0] im, input logic [15:0] off,
                         input logic [31:0] p, input string tag);
        @(negedge clk);
        in_valid  = 1'b1;
        opcode    = op;
        src_field = sf;
        dst_val   = dv;
        src_val   = sv;
        imm       = im;
        offset    = off;
        pc        = p;
        exp_q.push_back(model(op, sf, dv, sv, im, off, p));
        tag_q.push_back(tag);
    endtask

    // Monitor: compares every valid result against the queue head.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            exp_t  got;
            exp_t  want;
            string t;
            got = {taken, next_pc, call_req, call_kind, call_target, ret_addr, exit_req, illegal};
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R12 unexpected result: actual=%h expected=none", got);
            end else begin
                want = exp_q.pop_front();
                t    = tag_q.pop_front();
                if (got !== want) begin
                    errors++;
                    $display("FAIL %s: actual=%h expected=%h", t, got, want);
                end
            end
        end
    end

    task automatic run_tests();
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if ({out_valid, taken, next_pc, call_req, call_kind, call_target, ret_addr, exit_req, illegal} !== '0) begin
            errors++;
            $display("FAIL R1 reset: actual=%h expected=0", {taken, next_pc, illegal});
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || next_pc !== '0) begin
            errors++;
            $display("FAIL R1 after reset: actual=%b/%h expected=0/0", out_valid, next_pc);
        end
        // R4 eq/ne/set, R7 targets
        drive(8'h15, 4'd0, 64'd5, 64'd0, 32'd5, 16'd3, 32'd100, "R4_eq_imm_taken R7");
        drive(8'h15, 4'd0, 64'd6, 64'd0, 32'd5, 16'd3, 32'd100, "R4_eq_imm_not R7");
        drive(8'h5d, 4'd0, 64'h1_0000_0007, 64'h7, 32'd0, 16'd4, 32'd50, "R4_ne_reg R2");
        drive(8'h45, 4'd0, 64'hF0, 64'd0, 32'h10, 16'd2, 32'd10, "R4_set_hit");
        drive(8'h45, 4'd0, 64'hF0, 64'd0, 32'h0F, 16'd2, 32'd10, "R4_set_miss");
        // R2 width
        drive(8'h1d, 4'd0, 64'hAAAA_0000_1234_5678, 64'h5555_0000_1234_5678, 32'd0, 16'd1, 32'd7, "R2_wide_eq_hi_differ");
        drive(8'h1e, 4'd0, 64'hAAAA_0000_1234_5678, 64'h5555_0000_1234_5678, 32'd0, 16'd1, 32'd7, "R2_narrow_eq_hi_ignored");
        drive(8'h4e, 4'd0, 64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_0000_0000, 32'd0, 16'd1, 32'd7, "R2_narrow_set_hi_ignored");
        // R5 unsigned
        drive(8'h2d, 4'd0, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 32'd0, 16'd8, 32'd20, "R5_ugt");
        drive(8'had, 4'd0, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 32'd0, 16'd8, 32'd20, "R5_ult");
        drive(8'h3d, 4'd0, 64'd9, 64'd9, 32'd0, 16'd8, 32'd20, "R5_uge_equal");
        drive(8'hbd, 4'd0, 64'd10, 64'd9, 32'd0, 16'd8, 32'd20, "R5_ule_greater");
        drive(8'h2e, 4'd0, 64'h0000_0001_0000_0001, 64'h0000_0000_FFFF_FFFF, 32'd0, 16'd8, 32'd20, "R5_narrow_ugt R2");
        // R6 signed
        drive(8'h6d, 4'd0, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 32'd0, 16'd6, 32'd30, "R6_sgt");
        drive(8'hcd, 4'd0, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 32'd0, 16'd6, 32'd30, "R6_slt");
        drive(8'h7d, 4'd0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 32'd0, 16'd6, 32'd30, "R6_sge_equal");
        drive(8'hdd, 4'd0, 64'd0, 64'h8000_0000_0000_0000, 32'd0, 16'd6, 32'd30, "R6_sle_min");
        drive(8'hce, 4'd0, 64'h0000_0000_8000_0000, 64'd1, 32'd0, 16'd6, 32'd30, "R6_narrow_slt R2");
        // R3 immediate extension
        drive(8'ha5, 4'd0, 64'd5, 64'd0, 32'hFFFF_FFFF, 16'd2, 32'd40, "R3_wide_imm_sext_ult");
        drive(8'h25, 4'd0, 64'h1_0000_0000, 64'd0, 32'hFFFF_FFFF, 16'd2, 32'd40, "R3_wide_imm_sext_ugt");
        drive(8'ha6, 4'd0, 64'hFFFF_FFFF_0000_0005, 64'd0, 32'hFFFF_FFFF, 16'd2, 32'd40, "R3_narrow_imm_ult");
        drive(8'h65, 4'd0, 64'hFFFF_FFFF_FFFF_FFFE, 64'd0, 32'hFFFF_FFFF, 16'd2, 32'd40, "R3_wide_imm_sgt");
        drive(8'h1d, 4'd0, 64'd3, 64'd4, 32'd3, 16'd2, 32'd40, "R3_reg_not_imm");
        // R7 negative offset, R8 unconditional
        drive(8'h05, 4'd0, 64'd0, 64'd0, 32'd0, 16'hFFFB, 32'd100, "R8_ja R7_backward");
        drive(8'h05, 4'd0, 64'd0, 64'd0, 32'd0, 16'h7FFF, 32'd0, "R8_ja R7_max_offset");
        // R9 calls
        drive(8'h85, 4'd0, 64'd0, 64'd0, 32'h0000_1234, 16'd5, 32'd60, "R9_helper_addr");
        drive(8'h85, 4'd1, 64'd0, 64'd0, 32'd0, 16'd10, 32'd200, "R9_local");
        drive(8'h85, 4'd2, 64'd0, 64'd0, 32'h8000_0001, 16'd5, 32'd60, "R9_helper_type");
        drive(8'h85, 4'd3, 64'd0, 64'd0, 32'd1, 16'd5, 32'd60, "R9_bad_kind R11");
        // R10 exit
        drive(8'h95, 4'd0, 64'd0, 64'd0, 32'd0, 16'd9, 32'd70, "R10_exit");
        // R11 illegal
        drive(8'h06, 4'd0, 64'd0, 64'd0, 32'd0, 16'd9, 32'd70, "R11_narrow_ja");
        drive(8'h86, 4'd1, 64'd0, 64'd0, 32'd0, 16'd9, 32'd70, "R11_narrow_call");
        drive(8'h96, 4'd0, 64'd0, 64'd0, 32'd0, 16'd9, 32'd70, "R11_narrow_exit");
        drive(8'he5, 4'd0, 64'd0, 64'd0, 32'd0, 16'd9, 32'd70, "R11_code_e");
        drive(8'h15, 4'd0, 64'd0, 64'd0, 32'd0, 16'd9, 32'd70, "R11_legal_after");
        drive(8'h14, 4'd0, 64'd0, 64'd0, 32'd0, 16'd9, 32'd70, "R11_wrong_class");
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R12: idle outputs stay zero
        checks++;
        if (out_valid !== 1'b0 || taken !== 1'b0 || illegal !== 1'b0 || exp_q.size() != 0) begin
            errors++;
            $display("FAIL R12 idle: actual=%b%b%b pending=%0d expected=000 pending=0",
                     out_valid, taken, illegal, exp_q.size());
        end
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (5000) @(posedge clk);
                errors++;
                $display("FAIL R12 watchdog: actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule